// File: doc/BRIEF.md
# Float32 Normalized Mantissa Extractor

This unit takes one IEEE-754 single-precision value and returns a new float32 that keeps the source fraction but carries a rebuilt exponent. The magnitude of the result therefore lies in one of two ranges: [1,2) or [0.5,1). A 2-bit interval code picks the range. The code can fix the range, or it can choose the range from the parity of the source's unbiased exponent or from the top fraction bit. A 2-bit sign-control field decides the sign of the result. It can keep the source sign, force the result positive, or reject negative operands by returning the default quiet NaN.

Zeros, infinities and NaNs each produce a fixed result. A subnormal operand is first normalized: its fraction is shifted left until the leading one has left the field, and the exponent is decremented once per shift. A denormals-are-zero input instead makes subnormals behave like zero. Two flags report the outcome. One reports an invalid operation (a signaling NaN, or a negative operand rejected by sign control). The other reports that a subnormal was normalized.

The unit accepts one operand per cycle. Each result is registered and appears one cycle after its input, marked by an output valid. The flags are not sticky. They describe only the result presented in the same cycle.

Top module: `fmant_unit`

## Requirements
- R1: For a normal operand that is not rejected, the result fraction field (bits 22:0) equals the source fraction, and the exponent field (bits 30:23) is replaced.
- R2: The interval code sets the result exponent field as follows. Code 00 gives 127. Code 10 gives 126. Code 01 gives 126 if the unbiased source exponent is odd and 127 if it is even. Code 11 gives 126 if fraction bit 22 is set and 127 if it is clear.
- R3: With sign-control bit 0 set, the result sign (bit 31) is 0. With it clear, the result takes the source sign, unless another rule fixes the result.
- R4: A NaN operand (exponent 255, fraction nonzero) returns itself with fraction bit 22 set. The invalid flag is raised exactly when bit 22 was clear in the operand.
- R5: A positive zero or positive infinity returns 0x3F800000, with no flag.
- R6: A negative zero returns 0x3F800000 when sign-control bit 0 is set and 0xBF800000 when it is clear. A negative infinity with sign-control bit 1 clear follows the same rule.
- R7: With sign-control bit 1 set, a negative operand that is neither zero nor NaN returns 0xFFC00000 and raises invalid. This covers negative normals, negative subnormals and negative infinity. Bit 1 takes precedence over bit 0.
- R8: With denormals-are-zero asserted, an operand with exponent 0 and a nonzero fraction is handled as a zero of the same sign, and the denormal flag stays low. On other operands the input has no effect.
- R9: With denormals-are-zero low, a subnormal is normalized. The fraction is shifted left by (leading zeros + 1), and the parity and bit-22 tests use the shifted fraction and a count of that many decrements. The denormal flag is raised unless R7 rejects the operand.
- R10: out_valid follows in_valid one cycle later. The result changes only when a valid input was taken and holds otherwise. Both flags are 0 whenever out_valid is 0. Reset drives out_valid, out_result and both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls are presented this cycle |
| in_operand | input | EXP_W+FRAC_W+1 (32) | Source float |
| in_interval | input | 2 | Interval code |
| in_signctl | input | 2 | Sign control; bit 0 forces positive, bit 1 rejects negatives |
| in_daz | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Registered result is new this cycle |
| out_result | output | EXP_W+FRAC_W+1 (32) | Registered result float |
| out_invalid | output | 1 | Invalid operation for the current result |
| out_denormal | output | 1 | Current result came from a normalized subnormal |

## Verification
The checker watches several rules on every cycle. It checks the one-cycle valid timing, that the result holds while idle, and that the flags stay low while idle and never rise together. It checks that every non-NaN result has exponent 126 or 127, and that every invalid result is a quiet NaN. It also checks that fraction and sign are carried through for normal operands, and that interval code 10 gives exponent 126. The bench's vectors are needed to show the exact values for the special operands. These include parity and bit-22 selection after subnormal normalization, the precedence between the two sign-control bits, and denormals-are-zero turning a negative subnormal into -1.0 rather than a NaN.

// File: rtl/fmant_pkg.sv
package fmant_pkg;

  // operand classes after the denormals-are-zero decision
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } fcls_e;

  // interval selector codes
  typedef enum logic [1:0] {
    IV_ONE_TWO  = 2'b00,
    IV_PARITY   = 2'b01,
    IV_HALF_ONE = 2'b10,
    IV_TOPBIT   = 2'b11
  } fiv_e;

endpackage

// File: rtl/fmant_classify.sv
module fmant_classify
  import fmant_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W-1:0]  exp_in,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic              daz,
  output fcls_e             cls
);

  logic exp_zero, exp_full, frac_zero;

  always_comb begin
    exp_zero  = (exp_in == '0);
    exp_full  = (exp_in == '1);
    frac_zero = (frac_in == '0);
    if (exp_full)
      cls = frac_zero ? CLS_INF : CLS_NAN;
    else if (exp_zero)
      cls = (frac_zero || daz) ? CLS_ZERO : CLS_SUB;
    else
      cls = CLS_NORM;
  end

endmodule

// File: rtl/fmant_norm.sv
module fmant_norm #(
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W-1:0] frac_in,
  output logic [FRAC_W-1:0] frac_out,
  output logic              odd_exp
);

  localparam int LZ_W = $clog2(FRAC_W + 1);

  logic [LZ_W-1:0] lz;
  logic            found;
  logic [FRAC_W:0] shifted;

  // leading-zero count from the top fraction bit down
  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!found && frac_in[i]) begin
        lz    = LZ_W'(FRAC_W - 1 - i);
        found = 1'b1;
      end
    end
  end

  // shift by lz+1: the leading one leaves the field
  always_comb begin
    shifted  = {frac_in, 1'b0} << lz;
    frac_out = shifted[FRAC_W-1:0];
    // lz+1 decrements from the bias: odd when lz is even
    odd_exp  = ~lz[0];
  end

endmodule

// File: rtl/fmant_compose.sv
module fmant_compose
  import fmant_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    sign_in,
  input  logic [EXP_W-1:0]        exp_in,
  input  logic [FRAC_W-1:0]       frac_in,
  input  fcls_e                   cls,
  input  logic [FRAC_W-1:0]       nfrac,
  input  logic                    nodd,
  input  logic [1:0]              interval,
  input  logic [1:0]              signctl,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    invalid,
  output logic                    denormal
);

  localparam int W         = EXP_W + FRAC_W + 1;
  localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
  localparam logic BIAS_ODD = 1'(BIAS % 2);
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
  localparam logic [W-1:0] POS_ONE  = {1'b0, EXP_ONE, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] NEG_ONE  = {1'b1, EXP_ONE, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] DEF_QNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [FRAC_W-1:0] body_frac;
  logic              odd_exp, top_bit, out_sign, rejected;
  logic [EXP_W-1:0]  new_exp;
  logic [W-1:0]      signed_one;

  // exponent for the in-range mantissa
  always_comb begin
    body_frac = (cls == CLS_SUB) ? nfrac : frac_in;
    odd_exp   = (cls == CLS_SUB) ? nodd : (exp_in[0] ^ BIAS_ODD);
    top_bit   = body_frac[FRAC_W-1];
    case (fiv_e'(interval))
      IV_ONE_TWO:  new_exp = EXP_ONE;
      IV_PARITY:   new_exp = odd_exp ? EXP_HALF : EXP_ONE;
      IV_HALF_ONE: new_exp = EXP_HALF;
      default:     new_exp = top_bit ? EXP_HALF : EXP_ONE;
    endcase
    out_sign   = signctl[0] ? 1'b0 : sign_in;
    signed_one = signctl[0] ? POS_ONE : NEG_ONE;
    rejected   = sign_in && signctl[1];
  end

  // special-value selection
  always_comb begin
    result   = {out_sign, new_exp, body_frac};
    invalid  = 1'b0;
    denormal = 1'b0;
    case (cls)
      CLS_NAN: begin
        result  = {sign_in, exp_in, 1'b1, frac_in[FRAC_W-2:0]};
        invalid = ~frac_in[FRAC_W-1];
      end
      CLS_ZERO: begin
        result = sign_in ? signed_one : POS_ONE;
      end
      CLS_INF: begin
        if (!sign_in) begin
          result = POS_ONE;
        end else if (signctl[1]) begin
          result  = DEF_QNAN;
          invalid = 1'b1;
        end else begin
          result = signed_one;
        end
      end
      CLS_SUB, CLS_NORM: begin
        if (rejected) begin
          result  = DEF_QNAN;
          invalid = 1'b1;
        end else begin
          denormal = (cls == CLS_SUB);
        end
      end
      default: begin
        result  = DEF_QNAN;
        invalid = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/fmant_unit.sv
module fmant_unit
  import fmant_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] in_operand,
  input  logic [1:0]            in_interval,
  input  logic [1:0]            in_signctl,
  input  logic                  in_daz,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] out_result,
  output logic                  out_invalid,
  output logic                  out_denormal
);

  localparam int W = EXP_W + FRAC_W + 1;

  logic              op_sign;
  logic [EXP_W-1:0]  op_exp;
  logic [FRAC_W-1:0] op_frac;
  fcls_e             cls;
  logic [FRAC_W-1:0] nfrac;
  logic              nodd;
  logic [W-1:0]      res_d;
  logic              inv_d, den_d;

  assign op_sign = in_operand[W-1];
  assign op_exp  = in_operand[W-2:FRAC_W];
  assign op_frac = in_operand[FRAC_W-1:0];

  fmant_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
    .exp_in (op_exp),
    .frac_in(op_frac),
    .daz    (in_daz),
    .cls    (cls)
  );

  fmant_norm #(.FRAC_W(FRAC_W)) norm_i (
    .frac_in (op_frac),
    .frac_out(nfrac),
    .odd_exp (nodd)
  );

  fmant_compose #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) comp_i (
    .sign_in (op_sign),
    .exp_in  (op_exp),
    .frac_in (op_frac),
    .cls     (cls),
    .nfrac   (nfrac),
    .nodd    (nodd),
    .interval(in_interval),
    .signctl (in_signctl),
    .result  (res_d),
    .invalid (inv_d),
    .denormal(den_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_invalid  <= 1'b0;
      out_denormal <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_invalid  <= in_valid & inv_d;
      out_denormal <= in_valid & den_d;
      if (in_valid) out_result <= res_d;
    end
  end

endmodule

// File: rtl/fmant_unit_chk.sv
module fmant_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] in_operand,
  input logic [1:0]            in_interval,
  input logic [1:0]            in_signctl,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] out_result,
  input logic                  out_invalid,
  input logic                  out_denormal
);

  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);

  logic [EXP_W-1:0] in_exp, res_exp;
  logic             in_normal, kept;

  assign in_exp    = in_operand[W-2:FRAC_W];
  assign res_exp   = out_result[W-2:FRAC_W];
  assign in_normal = (in_exp != '0) && (in_exp != '1);
  assign kept      = in_valid && in_normal && !(in_operand[W-1] && in_signctl[1]);

  p_valid_lat_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));

  p_flags_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_invalid && !out_denormal);

  p_den_not_inv_r9: assert property (@(posedge clk) disable iff (rst)
    out_denormal |-> !out_invalid);

  p_inv_is_qnan_r4: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (res_exp == '1) && out_result[FRAC_W-1]);

  p_exp_range_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_exp != '1) |-> (res_exp == EXP_ONE || res_exp == EXP_HALF));

  p_half_code_r2: assert property (@(posedge clk) disable iff (rst)
    (kept && in_interval == 2'b10) |=> res_exp == EXP_HALF);

  p_frac_keep_r1: assert property (@(posedge clk) disable iff (rst)
    kept |=> out_result[FRAC_W-1:0] == $past(in_operand[FRAC_W-1:0]));

  p_force_pos_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_signctl == 2'b01 && in_exp != '1) |=> !out_result[W-1]);

  p_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (kept == 1'b0 && in_valid && in_normal && in_operand[W-1] && in_signctl[1])
      |=> out_invalid);

endmodule

bind fmant_unit fmant_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_operand  (in_operand),
  .in_interval (in_interval),
  .in_signctl  (in_signctl),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_invalid (out_invalid),
  .out_denormal(out_denormal)
);

// File: tb/fmant_unit_tb_top.sv
`timescale 1ns/1ps
module fmant_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_operand = '0;
  logic [1:0]  in_interval = '0;
  logic [1:0]  in_signctl = '0;
  logic        in_daz = 1'b0;
  logic        out_valid, out_invalid, out_denormal;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  fmant_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_interval(in_interval), .in_signctl(in_signctl), .in_daz(in_daz),
    .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid), .out_denormal(out_denormal)
  );

  typedef struct packed {
    logic [31:0] op;
    logic [1:0]  iv;
    logic [1:0]  sc;
    logic        daz;
    logic [31:0] res;
    logic        inv;
    logic        den;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{32'h40400000, 2'b00, 2'b00, 1'b0, 32'h3FC00000, 1'b0, 1'b0, 4'd1}, // R1 3.0
    '{32'h40400000, 2'b01, 2'b00, 1'b0, 32'h3F400000, 1'b0, 1'b0, 4'd2}, // R2 odd
    '{32'h40400000, 2'b10, 2'b00, 1'b0, 32'h3F400000, 1'b0, 1'b0, 4'd2}, // R2
    '{32'h40400000, 2'b11, 2'b00, 1'b0, 32'h3F400000, 1'b0, 1'b0, 4'd2}, // R2 bit22 set
    '{32'h40C00000, 2'b01, 2'b00, 1'b0, 32'h3FC00000, 1'b0, 1'b0, 4'd2}, // R2 even
    '{32'h40A00000, 2'b11, 2'b00, 1'b0, 32'h3FA00000, 1'b0, 1'b0, 4'd2}, // R2 bit22 clear
    '{32'h00800000, 2'b01, 2'b00, 1'b0, 32'h3F800000, 1'b0, 1'b0, 4'd2}, // R2 min normal
    '{32'h7F7FFFFF, 2'b01, 2'b00, 1'b0, 32'h3F7FFFFF, 1'b0, 1'b0, 4'd1}, // R1 max normal
    '{32'hC0400000, 2'b00, 2'b00, 1'b0, 32'hBFC00000, 1'b0, 1'b0, 4'd3}, // R3 keep sign
    '{32'hC0400000, 2'b00, 2'b01, 1'b0, 32'h3FC00000, 1'b0, 1'b0, 4'd3}, // R3 force +
    '{32'hC0400000, 2'b00, 2'b10, 1'b0, 32'hFFC00000, 1'b1, 1'b0, 4'd7}, // R7
    '{32'hC0400000, 2'b01, 2'b11, 1'b0, 32'hFFC00000, 1'b1, 1'b0, 4'd7}, // R7 precedence
    '{32'h7F800001, 2'b00, 2'b00, 1'b0, 32'h7FC00001, 1'b1, 1'b0, 4'd4}, // R4 sNaN
    '{32'hFFC00005, 2'b10, 2'b10, 1'b0, 32'hFFC00005, 1'b0, 1'b0, 4'd4}, // R4 qNaN
    '{32'hFF800001, 2'b00, 2'b01, 1'b0, 32'hFFC00001, 1'b1, 1'b0, 4'd4}, // R4 neg sNaN
    '{32'h00000000, 2'b10, 2'b00, 1'b0, 32'h3F800000, 1'b0, 1'b0, 4'd5}, // R5 +0
    '{32'h7F800000, 2'b01, 2'b10, 1'b0, 32'h3F800000, 1'b0, 1'b0, 4'd5}, // R5 +inf
    '{32'h80000000, 2'b00, 2'b00, 1'b0, 32'hBF800000, 1'b0, 1'b0, 4'd6}, // R6 -0
    '{32'h80000000, 2'b00, 2'b11, 1'b0, 32'h3F800000, 1'b0, 1'b0, 4'd6}, // R6 -0 no reject
    '{32'hFF800000, 2'b00, 2'b00, 1'b0, 32'hBF800000, 1'b0, 1'b0, 4'd6}, // R6 -inf
    '{32'hFF800000, 2'b11, 2'b01, 1'b0, 32'h3F800000, 1'b0, 1'b0, 4'd6}, // R6 -inf +
    '{32'hFF800000, 2'b00, 2'b10, 1'b0, 32'hFFC00000, 1'b1, 1'b0, 4'd7}, // R7 -inf
    '{32'h00400000, 2'b00, 2'b00, 1'b0, 32'h3F800000, 1'b0, 1'b1, 4'd9}, // R9 one shift
    '{32'h00400000, 2'b01, 2'b00, 1'b0, 32'h3F000000, 1'b0, 1'b1, 4'd9}, // R9 odd count
    '{32'h00300000, 2'b11, 2'b00, 1'b0, 32'h3F400000, 1'b0, 1'b1, 4'd9}, // R9 bit22 after shift
    '{32'h00300000, 2'b01, 2'b00, 1'b0, 32'h3FC00000, 1'b0, 1'b1, 4'd9}, // R9 even count
    '{32'h00000001, 2'b01, 2'b00, 1'b0, 32'h3F000000, 1'b0, 1'b1, 4'd9}, // R9 23 shifts
    '{32'h80400000, 2'b00, 2'b00, 1'b0, 32'hBF800000, 1'b0, 1'b1, 4'd9}, // R9 negative
    '{32'h80400000, 2'b00, 2'b10, 1'b0, 32'hFFC00000, 1'b1, 1'b0, 4'd7}, // R7 neg subnormal
    '{32'h00400000, 2'b01, 2'b00, 1'b1, 32'h3F800000, 1'b0, 1'b0, 4'd8}, // R8 DAZ +
    '{32'h80300000, 2'b00, 2'b10, 1'b1, 32'hBF800000, 1'b0, 1'b0, 4'd8}, // R8 DAZ - not NaN
    '{32'h40400000, 2'b01, 2'b00, 1'b1, 32'h3F400000, 1'b0, 1'b0, 4'd8}  // R8 normal unaffected
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] last;
    repeat (3) @(negedge clk);
    // reset state, R10
    chk("R10 reset valid", 32'(out_valid), 32'd0);
    chk("R10 reset result", out_result, 32'h0);
    chk("R10 reset flags", {30'd0, out_invalid, out_denormal}, 32'd0);
    rst = 1'b0;

    // table walk, back to back
    for (int i = 0; i < NV; i++) begin
      in_valid    = 1'b1;
      in_operand  = VECS[i].op;
      in_interval = VECS[i].iv;
      in_signctl  = VECS[i].sc;
      in_daz      = VECS[i].daz;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d result", VECS[i].req, i), out_result, VECS[i].res);
      chk($sformatf("R%0d vec%0d flags", VECS[i].req, i),
          {30'd0, out_invalid, out_denormal}, {30'd0, VECS[i].inv, VECS[i].den});
      chk($sformatf("R10 vec%0d valid", i), 32'(out_valid), 32'd1);
    end

    // R10: idle cycle holds result, drops flags
    in_valid = 1'b1; in_operand = 32'h7F800001; in_interval = 2'b00;
    in_signctl = 2'b00; in_daz = 1'b0;
    @(negedge clk);
    chk("R4 sNaN before idle", out_result, 32'h7FC00001);
    chk("R4 invalid before idle", 32'(out_invalid), 32'd1);
    last = out_result;
    in_valid = 1'b0; in_operand = 32'h00400000;
    @(negedge clk);
    chk("R10 idle valid", 32'(out_valid), 32'd0);
    chk("R10 idle hold", out_result, last);
    chk("R10 idle flags", {30'd0, out_invalid, out_denormal}, 32'd0);
    @(negedge clk);
    chk("R10 idle hold 2", out_result, last);

    // R8: DAZ ignored for a subnormal-free operand at interval 11
    in_valid = 1'b1; in_operand = 32'h40A00000; in_interval = 2'b11; in_daz = 1'b1;
    @(negedge clk);
    chk("R8 daz normal", out_result, 32'h3FA00000);

    // R10: reset mid-stream clears everything
    in_operand = 32'hFF800000; in_signctl = 2'b10; rst = 1'b1;
    @(negedge clk);
    chk("R10 mid reset result", out_result, 32'h0);
    chk("R10 mid reset flags", {30'd0, out_invalid, out_denormal}, 32'd0);
    chk("R10 mid reset valid", 32'(out_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 after reset", out_result, 32'hFFC00000);
    in_valid = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule